// File: doc/BRIEF.md
# SPI Flash Status-Register Write Protection

This block is the command and status-register slice of a serial NOR flash slave. A byte-level front end delivers bytes received while chip select is low; the block decodes the write-enable, write-disable, read-status and write-status commands. It holds a write-enable latch, a sticky status-write-lock bit and a quad-enable bit, and it returns the status byte while a read-status frame stays open.

An active-low write-protect pin, resynchronised by a two-flop chain, works together with the lock bit. With the pin low and the lock bit set the status register is hardware-locked. Every other combination is software-protected, and an enabled status write is accepted. A status write commits only when chip select rises after a complete data byte. Each commit clears the write-enable latch, whether the write was accepted or refused.

Top module: `spi_sr_protect`

## Requirements
- R1: After reset the status byte reads 0x00 and the synchronised protect pin is taken as high (not protected).
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it; the latch is reported in status bit 1.
- R3: After opcode 0x05 the output carries the status byte {bit7 lock, bit6 quad-enable (0 when QUAD_REPORT=0), bits 5..2 zero, bit1 write-enable, bit0 zero} for every cycle chip select stays low. Outside such a frame the output is 0xFF.
- R4: Opcode 0x01 followed by data commits on the rising edge of chip select. Only the first data byte counts: its bit 7 loads the lock bit and its bit 6 loads quad-enable.
- R5: A status write is refused when the write-enable latch is clear.
- R6: A status write is refused when the protect pin is low and the lock bit is set. A refused write leaves lock and quad-enable unchanged.
- R7: With the pin high, an enabled write can both set and clear the lock bit. With the pin low and the lock bit clear, an enabled write is accepted and can set the lock bit.
- R8: Every committed status write clears the write-enable latch, whether it was accepted or refused.
- R9: A write-status frame closed before its data byte is complete is discarded: no status bit changes and the write-enable latch keeps its value.
- R10: The protect pin passes through a two-flop synchronizer and is evaluated at the commit cycle. A pin change that reaches the pins within fewer than two clocks of the commit does not yet count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low, frames a command |
| rx_valid_i | input | 1 | One-cycle strobe: rx_byte_i holds a received byte |
| rx_byte_i | input | 8 | Received byte |
| wp_ni | input | 1 | Write-protect pin, active low, asynchronous |
| tx_byte_o | output | 8 | Status byte during a read-status frame, else 0xFF |

## Verification
The assertions assume that rx_valid_i is only pulsed while cs_ni is low and never in the cycle where chip select rises. They also assume that the synchronizer's reset value stands for the pin until two clocks after reset. The bench drives each byte as a single-cycle strobe inside an open frame and keeps chip select high for several cycles between frames. It moves the protect pin only between frames, except in the one test that deliberately changes the pin in the commit cycle to expose the synchronizer delay.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_WRSR = 8'h01;
  localparam logic [BYTE_W-1:0] OP_WRDI = 8'h04;
  localparam logic [BYTE_W-1:0] OP_RDSR = 8'h05;
  localparam logic [BYTE_W-1:0] OP_WREN = 8'h06;

  typedef enum logic [2:0] {
    S_OPC,    // awaiting opcode
    S_WDATA,  // write-status opcode seen, awaiting data
    S_WFULL,  // data byte held, awaiting chip-select rise
    S_RD,     // streaming status
    S_SKIP    // rest of frame ignored
  } frame_st_e;
endpackage

// File: rtl/wp_sync.sv
module wp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wp_i,
  output logic wp_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;  // pin taken as high until sampled
    else         ff_q <= {ff_q[STAGES-2:0], wp_i};
  end

  assign wp_o = ff_q[STAGES-1];

  // cycles since reset, saturating at STAGES
  logic [$clog2(STAGES+1)-1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        age_q <= '0;
    else if (age_q != STAGES[$clog2(STAGES+1)-1:0]) age_q <= age_q + 1'b1;
  end

  assert_sync_delay_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == STAGES[$clog2(STAGES+1)-1:0]) |-> (wp_o == $past(wp_i, STAGES)));

  assert_reset_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == '0) |-> wp_o);
endmodule

// File: rtl/sr_frame_dec.sv
module sr_frame_dec
  import spi_sr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic              set_wel_o,
  output logic              clr_wel_o,
  output logic              commit_o,
  output logic [1:0]        wdata_o,
  output logic              rd_active_o
);
  frame_st_e st_q, st_d;
  logic      cs_q;
  logic [1:0] data_q;
  logic      byte_in;

  assign byte_in = rx_valid_i && !cs_ni;

  always_comb begin
    st_d = st_q;
    if (cs_ni) begin
      st_d = S_OPC;
    end else if (rx_valid_i) begin
      unique case (st_q)
        S_OPC: begin
          unique case (rx_byte_i)
            OP_RDSR: st_d = S_RD;
            OP_WRSR: st_d = S_WDATA;
            default: st_d = S_SKIP;
          endcase
        end
        S_WDATA: st_d = S_WFULL;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_OPC;
      cs_q   <= 1'b1;
      data_q <= '0;
    end else begin
      st_q <= st_d;
      cs_q <= cs_ni;
      if (byte_in && st_q == S_WDATA) data_q <= rx_byte_i[7:6];
    end
  end

  assign set_wel_o   = byte_in && st_q == S_OPC && rx_byte_i == OP_WREN;
  assign clr_wel_o   = byte_in && st_q == S_OPC && rx_byte_i == OP_WRDI;
  assign commit_o    = cs_ni && !cs_q && st_q == S_WFULL;
  assign wdata_o     = data_q;
  assign rd_active_o = !cs_ni && st_q == S_RD;

  assert_commit_on_cs_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $rose(cs_ni));

  assert_no_cmd_pulse_overlap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({set_wel_o, clr_wel_o, commit_o}));
endmodule

// File: rtl/sr_regs.sv
module sr_regs #(
  parameter bit QUAD_REPORT = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_wel_i,
  input  logic       clr_wel_i,
  input  logic       commit_i,
  input  logic [1:0] wdata_i,   // [1] lock, [0] quad-enable
  input  logic       wp_i,      // synchronised pin, low = protect
  output logic [7:0] status_o
);
  logic wel_q, lock_q, qe_q;
  logic hw_locked, accept;

  assign hw_locked = !wp_i && lock_q;
  assign accept    = commit_i && wel_q && !hw_locked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q  <= 1'b0;
      lock_q <= 1'b0;
      qe_q   <= 1'b0;
    end else begin
      if (commit_i)       wel_q <= 1'b0;
      else if (set_wel_i) wel_q <= 1'b1;
      else if (clr_wel_i) wel_q <= 1'b0;
      if (accept) begin
        lock_q <= wdata_i[1];
        qe_q   <= wdata_i[0];
      end
    end
  end

  generate
    if (QUAD_REPORT) begin : g_qe
      assign status_o = {lock_q, qe_q, 4'b0000, wel_q, 1'b0};
    end else begin : g_noqe
      assign status_o = {lock_q, 1'b0, 4'b0000, wel_q, 1'b0};
    end
  endgenerate

  assert_refuse_no_wel_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !wel_q) |=> ($stable(lock_q) && $stable(qe_q)));

  assert_refuse_hw_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !wp_i && lock_q) |=> ($stable(lock_q) && $stable(qe_q)));

  assert_accept_loads_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && wel_q && (wp_i || !lock_q)) |=> (lock_q == $past(wdata_i[1])));

  assert_wel_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> !wel_q);
endmodule

// File: rtl/spi_sr_protect.sv
module spi_sr_protect
  import spi_sr_pkg::*;
#(
  parameter bit          QUAD_REPORT = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              wp_ni,
  output logic [BYTE_W-1:0] tx_byte_o
);
  logic       wp_s;
  logic       set_wel, clr_wel, commit, rd_active;
  logic [1:0] wdata;
  logic [7:0] status;

  wp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wp_i  (wp_ni),
    .wp_o  (wp_s)
  );

  sr_frame_dec u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .rx_valid_i (rx_valid_i),
    .rx_byte_i  (rx_byte_i),
    .set_wel_o  (set_wel),
    .clr_wel_o  (clr_wel),
    .commit_o   (commit),
    .wdata_o    (wdata),
    .rd_active_o(rd_active)
  );

  sr_regs #(.QUAD_REPORT(QUAD_REPORT)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_wel_i(set_wel),
    .clr_wel_i(clr_wel),
    .commit_i (commit),
    .wdata_i  (wdata),
    .wp_i     (wp_s),
    .status_o (status)
  );

  assign tx_byte_o = rd_active ? status : '1;

  assert_status_reserved_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_active |-> (tx_byte_o[5:2] == 4'b0000 && !tx_byte_o[0]));

  assert_idle_ff_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> (tx_byte_o == 8'hFF));
endmodule

// File: tb/sim_spi_sr_protect.sv
module sim_spi_sr_protect;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_byte_i = 8'h00;
  logic       wp_ni = 1'b1;
  logic [7:0] tx_byte_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // model of status bits
  bit m_lock = 0, m_qe = 0;

  always #4 clk_i = ~clk_i;

  spi_sr_protect u0 (.*);

  // stimulus vectors: {wp, do_wren, data}
  typedef struct packed {
    logic       wp;
    logic       wren;
    logic [7:0] data;
  } vec_t;
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 8'h80}, '{1'b1, 1'b1, 8'h00}, '{1'b0, 1'b1, 8'hC0},
    '{1'b0, 1'b1, 8'h00}, '{1'b1, 1'b0, 8'h00}, '{1'b1, 1'b1, 8'h00},
    '{1'b0, 1'b0, 8'h80}, '{1'b0, 1'b1, 8'h40}};

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk_i); rx_valid_i = 1'b1; rx_byte_i = b;
    @(negedge clk_i); rx_valid_i = 1'b0;
  endtask

  task automatic open_f();
    @(negedge clk_i); cs_ni = 1'b0;
  endtask

  task automatic close_f();
    @(negedge clk_i); cs_ni = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic read_sr(output logic [7:0] s);
    open_f(); send(8'h05); s = tx_byte_o; close_f();
  endtask

  task automatic cmd(logic [7:0] op);
    open_f(); send(op); close_f();
  endtask

  task automatic wrsr(logic [7:0] d);
    open_f(); send(8'h01); send(d); close_f();
  endtask

  task automatic set_wp(logic v);
    @(negedge clk_i); wp_ni = v;
    repeat (4) @(negedge clk_i);
  endtask

  function automatic logic [7:0] exp_sr(bit wel);
    return {m_lock, m_qe, 4'b0000, wel, 1'b0};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] s;
    repeat (3) @(negedge clk_i);
    check("R3 idle ff in reset", tx_byte_o, 8'hFF);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R1 reset state
    read_sr(s); check("R1 reset status", s, 8'h00);

    // R2 write enable / disable
    cmd(8'h06); read_sr(s); check("R2 wren sets bit1", s, 8'h02);
    cmd(8'h04); read_sr(s); check("R2 wrdi clears bit1", s, 8'h00);

    // R3 repeated status and idle value
    cmd(8'h06);
    open_f(); send(8'h05); s = tx_byte_o; check("R3 first status byte", s, 8'h02);
    send(8'h00); check("R3 repeated status byte", tx_byte_o, 8'h02);
    repeat (3) @(negedge clk_i);
    check("R3 status held while cs low", tx_byte_o, 8'h02);
    close_f();
    check("R3 idle ff after frame", tx_byte_o, 8'hFF);
    cmd(8'h04);

    // table walk: R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      bit acc;
      set_wp(VECS[i].wp);
      if (VECS[i].wren) cmd(8'h06);
      acc = VECS[i].wren && !(VECS[i].wp == 1'b0 && m_lock);
      wrsr(VECS[i].data);
      if (acc) begin
        m_lock = VECS[i].data[7];
        m_qe   = VECS[i].data[6];
      end
      read_sr(s);
      check(acc ? "R7 accepted write (R4 R8)" : "R6 R5 refused write (R8)", s, exp_sr(0));
    end
    set_wp(1'b1);

    // R4 only the first data byte counts
    cmd(8'h06);
    open_f(); send(8'h01); send(8'h80); send(8'h40); close_f();
    m_lock = 1; m_qe = 0;
    read_sr(s); check("R4 first data byte only", s, exp_sr(0));

    // R9 frame cut before data byte: discarded, latch kept
    cmd(8'h06);
    open_f(); send(8'h01); close_f();
    read_sr(s); check("R9 truncated frame discarded", s, exp_sr(1));
    cmd(8'h04);

    // R8 refused under hardware lock still clears latch
    set_wp(1'b0);
    cmd(8'h06);
    wrsr(8'h00);
    read_sr(s); check("R8 R6 refused clears wel", s, exp_sr(0));

    // R10 pin raised in the commit cycle is not yet seen: still refused
    cmd(8'h06);
    open_f(); send(8'h01); send(8'h00);
    @(negedge clk_i); cs_ni = 1'b1; wp_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    read_sr(s); check("R10 late pin rise not seen", s, exp_sr(0));

    // R10 pin lowered in the commit cycle: still high at commit, accepted
    cmd(8'h06);
    open_f(); send(8'h01); send(8'h00);
    @(negedge clk_i); cs_ni = 1'b1; wp_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    m_lock = 0; m_qe = 0;
    read_sr(s); check("R10 late pin fall not seen", s, exp_sr(0));
    set_wp(1'b1);

    // unknown opcode ignored
    cmd(8'h06); cmd(8'h9F);
    read_sr(s); check("R2 unknown opcode leaves wel", s, exp_sr(1));

    // R1 reset clears everything
    cmd(8'h06); wrsr(8'hC0);
    @(negedge clk_i); rst_ni = 1'b0;
    repeat (2) @(negedge clk_i); rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    m_lock = 0; m_qe = 0;
    read_sr(s); check("R1 status after second reset", s, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule